// File: doc/BRIEF.md
# Register Read Request Frame Generator

This block produces the byte stream for a read request addressed to a battery management unit on a serial link running at 9600 baud. Each request is a fixed nine-byte frame. The frame opens with a colon character (0x3A) and closes with carriage return and line feed. Between them sit the target address, the register index, a request direction code, a constant payload byte, an additive check byte and a carry byte. The bytes leave one at a time through a valid/ready handshake toward a UART transmitter. That transmitter takes each byte at its own pace, and the block holds the current byte until it is accepted.

Requests start in one of two ways. A start pulse issues one request for the address and register index present on the inputs. When polling is enabled, the block instead works through a short list of register indices, one request per entry, and waits a programmable number of idle cycles between requests. Index 0 is never sent, because the unit does not answer it. A start pulse with index 0 does nothing, and zero entries in the poll list are passed over.

Top module: `regq_req_gen`

## Requirements
- R1: A frame is exactly nine bytes in this order: 0x3A, address, register index, direction code 0x01, payload 0x0B (decimal 11), check, carry, 0x0D, 0x0A; the first byte offered after idle is always 0x3A.
- R2: The check byte (sixth byte) equals (address + register + 0x01 + 0x0B) mod 256; the leading 0x3A does not take part in the sum.
- R3: The carry byte (seventh byte) equals the untruncated sum of R2 shifted right by 8 (0 when the sum is below 256, up to 2 for address 0xFF and register 0xFF).
- R4: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` does not change; each accepted handshake advances exactly one byte.
- R5: After reset the outputs `tx_valid_o`, `busy_o` and `done_o` are low. `done_o` is high for exactly one cycle, the cycle after the final 0x0A byte is accepted, and `busy_o` is low in that cycle.
- R6: A start pulse while a frame is in progress is ignored: the frame under way keeps its address and register, and no extra frame follows.
- R7: A start pulse whose register index is 0 is ignored: no frame is produced.
- R8: With `poll_en_i` high, entries k = 0 .. `poll_count_i`-1 of `poll_list_i` (entry k at bits [8k+7:8k]) are requested in cyclic order, with a count of 0 acting as 1. With `tx_ready_i` held high, the number of cycles with `tx_valid_o` low between two consecutive frames is `gap_i` + 1.
- R9: A poll list entry of 0 is skipped without a frame; each skipped entry adds exactly one cycle to the low time of R8.
- R10: When a valid start pulse arrives in the same cycle that a poll request would launch, the start wins. The poll position does not advance, and the following poll request comes `gap_i` + 1 low cycles after the manual frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single request pulse |
| addr_i | input | 8 | Target unit address (22 on typical links) |
| reg_i | input | 8 | Register index for a single request |
| poll_en_i | input | 1 | Enables list polling |
| poll_count_i | input | $clog2(LIST_DEPTH+1) | Number of active poll list entries |
| poll_list_i | input | LIST_DEPTH*8 | Poll register indices, entry k at bits [8k+7:8k] |
| gap_i | input | GAP_W | Idle cycles between poll requests |
| tx_ready_i | input | 1 | Transmitter accepts the offered byte |
| tx_data_o | output | 8 | Offered frame byte |
| tx_valid_o | output | 1 | A byte is offered |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse after the last byte is accepted |

## Verification
The start pulse and the poll scheduler's launch can fall in the same cycle. The bench drives this case on purpose. With a nonzero gap, it counts the low cycles of `tx_valid_o` after a poll frame and raises a start exactly in the cycle in which the count reaches `gap_i` + 1, which is the cycle the poll launch is due. The next frame must carry the manual register index. The frame after that must carry the poll entry that was due, not the one after it, with the normal gap before it. Around this, the bench sweeps every nonzero register index under several addresses and transmitter stall patterns, and computes the check and carry bytes arithmetically.

// File: rtl/regq_pkg.sv
package regq_pkg;

   localparam logic [7:0] SOF_BYTE    = 8'h3A;
   localparam logic [7:0] DIR_REQ     = 8'h01;
   localparam logic [7:0] REQ_PAYLOAD = 8'd11;
   localparam logic [7:0] CR_BYTE     = 8'h0D;
   localparam logic [7:0] LF_BYTE     = 8'h0A;
   localparam int         FRAME_LEN   = 9;

   // position of the byte currently offered within a frame
   typedef enum logic [3:0] {
      P_SOF   = 4'd0,
      P_ADDR  = 4'd1,
      P_REG   = 4'd2,
      P_DIR   = 4'd3,
      P_PAY   = 4'd4,
      P_CHK   = 4'd5,
      P_CARRY = 4'd6,
      P_CR    = 4'd7,
      P_LF    = 4'd8
   } fpos_e;

endpackage

// File: rtl/regq_frame_mux.sv
module regq_frame_mux
   import regq_pkg::*;
(
   input  logic [7:0] addr_i,
   input  logic [7:0] reg_i,
   input  fpos_e      pos_i,
   output logic [7:0] byte_o
);

   // untruncated sum; low byte is the check, upper bits the carry
   logic [9:0] sum_w;
   assign sum_w = 10'(addr_i) + 10'(reg_i) + 10'(DIR_REQ) + 10'(REQ_PAYLOAD);

   always_comb begin
      case (pos_i)
         P_SOF:   byte_o = SOF_BYTE;
         P_ADDR:  byte_o = addr_i;
         P_REG:   byte_o = reg_i;
         P_DIR:   byte_o = DIR_REQ;
         P_PAY:   byte_o = REQ_PAYLOAD;
         P_CHK:   byte_o = sum_w[7:0];
         P_CARRY: byte_o = {6'b0, sum_w[9:8]};
         P_CR:    byte_o = CR_BYTE;
         P_LF:    byte_o = LF_BYTE;
         default: byte_o = 8'h00;
      endcase
   end

endmodule

// File: rtl/regq_poll_sched.sv
module regq_poll_sched #(
   parameter int LIST_DEPTH = 8,
   parameter int GAP_W      = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              enable_i,
   input  logic                              busy_i,
   input  logic                              block_i,
   input  logic [$clog2(LIST_DEPTH+1)-1:0]   count_i,
   input  logic [LIST_DEPTH*8-1:0]           list_i,
   input  logic [GAP_W-1:0]                  gap_i,
   output logic                              fire_o,
   output logic [7:0]                        reg_o
);

   localparam int SEL_W = $clog2(LIST_DEPTH);
   localparam int CNT_W = $clog2(LIST_DEPTH+1);

   generate
      if (LIST_DEPTH < 2) begin : g_bad_depth
         $error("regq_poll_sched: LIST_DEPTH must be at least 2");
      end
      if (GAP_W < 1) begin : g_bad_gap
         $error("regq_poll_sched: GAP_W must be at least 1");
      end
   endgenerate

   logic [7:0] entry [LIST_DEPTH];

   generate
      for (genvar g = 0; g < LIST_DEPTH; g++) begin : g_unpack
         assign entry[g] = list_i[g*8 +: 8];
      end
   endgenerate

   logic [SEL_W-1:0] sel_q, sel_nxt;
   logic [GAP_W-1:0] gap_q;
   logic [CNT_W-1:0] sel_plus;
   logic             due_w, advance_w, wrap_w;

   assign due_w     = enable_i && !busy_i && (gap_q >= gap_i);
   assign advance_w = due_w && !block_i;
   assign sel_plus  = CNT_W'(sel_q) + CNT_W'(1);
   assign wrap_w    = (sel_plus >= count_i) || (sel_q == SEL_W'(LIST_DEPTH-1));
   assign sel_nxt   = wrap_w ? '0 : sel_q + SEL_W'(1);

   assign reg_o  = entry[sel_q];
   assign fire_o = advance_w && (entry[sel_q] != 8'd0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
         gap_q <= '0;
      end else begin
         if (!enable_i)      sel_q <= '0;
         else if (advance_w) sel_q <= sel_nxt;

         if (!enable_i || busy_i) gap_q <= '0;
         else if (gap_q != '1)    gap_q <= gap_q + GAP_W'(1);
      end
   end

   // a zero entry is passed over without starting a frame
   assert_skip_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (advance_w && entry[sel_q] == 8'd0) |=> !busy_i);

   // a manual start that wins the cycle leaves the poll position in place
   assert_start_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (due_w && block_i && enable_i) |=> $stable(sel_q));

endmodule

// File: rtl/regq_req_gen.sv
module regq_req_gen
   import regq_pkg::*;
#(
   parameter int LIST_DEPTH = 8,
   parameter int GAP_W      = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start_i,
   input  logic [7:0]                        addr_i,
   input  logic [7:0]                        reg_i,
   input  logic                              poll_en_i,
   input  logic [$clog2(LIST_DEPTH+1)-1:0]   poll_count_i,
   input  logic [LIST_DEPTH*8-1:0]           poll_list_i,
   input  logic [GAP_W-1:0]                  gap_i,
   input  logic                              tx_ready_i,
   output logic [7:0]                        tx_data_o,
   output logic                              tx_valid_o,
   output logic                              busy_o,
   output logic                              done_o
);

   generate
      if (FRAME_LEN != 9) begin : g_bad_len
         $error("regq_req_gen: frame position encoding expects nine bytes");
      end
   endgenerate

   logic       busy_q, done_q;
   fpos_e      pos_q;
   logic [7:0] addr_q, reg_q;
   logic       start_ok, poll_fire, launch, last_acc;
   logic [7:0] poll_reg;

   assign start_ok = start_i && !busy_q && (reg_i != 8'd0);
   assign launch   = start_ok || poll_fire;
   assign last_acc = busy_q && tx_ready_i && (pos_q == P_LF);

   regq_poll_sched #(
      .LIST_DEPTH (LIST_DEPTH),
      .GAP_W      (GAP_W)
   ) u_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (poll_en_i),
      .busy_i   (busy_q),
      .block_i  (start_ok),
      .count_i  (poll_count_i),
      .list_i   (poll_list_i),
      .gap_i    (gap_i),
      .fire_o   (poll_fire),
      .reg_o    (poll_reg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         pos_q  <= P_SOF;
         addr_q <= '0;
         reg_q  <= '0;
      end else begin
         done_q <= last_acc;
         if (launch) begin
            busy_q <= 1'b1;
            pos_q  <= P_SOF;
            addr_q <= addr_i;
            reg_q  <= start_ok ? reg_i : poll_reg;
         end else if (busy_q && tx_ready_i) begin
            if (pos_q == P_LF) busy_q <= 1'b0;
            else               pos_q  <= fpos_e'(pos_q + 4'd1);
         end
      end
   end

   regq_frame_mux u_mux (
      .addr_i (addr_q),
      .reg_i  (reg_q),
      .pos_i  (pos_q),
      .byte_o (tx_data_o)
   );

   assign tx_valid_o = busy_q;
   assign busy_o     = busy_q;
   assign done_o     = done_q;

   assert_sof_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid_o) |-> tx_data_o == SOF_BYTE);

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_after_lf_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(tx_data_o) == LF_BYTE && $past(tx_ready_i) && !busy_o));

   assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_q && !last_acc) |=> (busy_q && $stable(reg_q) && $stable(addr_q)));

   assert_no_zero_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o |-> reg_q != 8'd0);

endmodule

// File: tb/tb_regq_req_gen.sv
module tb_regq_req_gen;

   localparam int DEPTH = 4;
   localparam int GW    = 4;
   localparam int CW    = $clog2(DEPTH+1);

   logic            clk = 1'b0, rst_n = 1'b0, start = 1'b0, poll_en = 1'b0, tx_ready = 1'b0;
   logic [7:0]      addr = 8'd0, regi = 8'd0;
   logic [CW-1:0]   pcount = '0;
   logic [DEPTH*8-1:0] plist = '0;
   logic [GW-1:0]   gap = '0;
   logic [7:0]      tx_data;
   logic            tx_valid, busy, done;

   regq_req_gen #(.LIST_DEPTH(DEPTH), .GAP_W(GW)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .reg_i(regi),
      .poll_en_i(poll_en), .poll_count_i(pcount), .poll_list_i(plist), .gap_i(gap),
      .tx_ready_i(tx_ready), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
      .busy_o(busy), .done_o(done));

   always #2 clk = ~clk;

   int n_chk = 0, n_bad = 0, cyc = 0;
   logic [7:0] got [9];
   int got_n = 0, idle_lo = 0;
   int lst [DEPTH];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   initial begin
      wait (cyc >= 150000);
      chk(1'b0, "watchdog expired", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   // capture one frame; idle_lo counts low negedges including the previous done cycle
   task automatic grab(input int rmode, input bit inject, input int collide_at,
                       input logic [7:0] collide_reg);
      int k = 0;
      bit pend = 1'b0;
      logic [7:0] hv = 8'h00;
      got_n = 0;
      idle_lo = 1;
      while (got_n < 9) begin
         @(negedge clk);
         start = 1'b0;
         k++;
         case (rmode)
            0:       tx_ready = 1'b1;
            1:       tx_ready = (k % 2) == 1;
            default: tx_ready = (k % 3) == 2;
         endcase
         if (pend) begin
            chk(tx_valid && tx_data == hv, "R4 byte held while not ready", int'(tx_data), int'(hv));
            pend = 1'b0;
         end
         if (!tx_valid) begin
            if (got_n == 0) begin
               idle_lo++;
               if (collide_at > 0 && idle_lo == collide_at) begin
                  start = 1'b1;
                  regi  = collide_reg;
               end
            end
         end else if (tx_ready) begin
            got[got_n] = tx_data;
            got_n++;
            if (inject && got_n == 4) begin
               start = 1'b1;
               regi  = regi ^ 8'h41;
            end
         end else begin
            pend = 1'b1;
            hv   = tx_data;
         end
      end
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic check_frame(input int a, input int r, input string where);
      int s = a + r + 1 + 11;
      chk(got[0] == 8'h3A && got[1] == a[7:0] && got[2] == r[7:0] && got[3] == 8'h01 &&
          got[4] == 8'd11 && got[7] == 8'h0D && got[8] == 8'h0A,
          {"R1 frame layout ", where}, int'(got[2]), r);
      chk(got[5] == s[7:0], {"R2 check byte ", where}, int'(got[5]), s % 256);
      chk(got[6] == 8'(s >> 8), {"R3 carry byte ", where}, int'(got[6]), s >> 8);
      chk(done === 1'b1 && busy === 1'b0, {"R5 done pulse ", where}, int'(done), 1);
   endtask

   task automatic next_entry(inout int p, input int cnt, output int er, output int sk);
      int ce = (cnt == 0) ? 1 : cnt;
      sk = 0;
      er = 0;
      for (int t = 0; t < 2 * DEPTH + 2; t++) begin
         int e = lst[p];
         p = (p + 1 >= ce) ? 0 : p + 1;
         if (e != 0) begin
            er = e;
            break;
         end
         sk++;
      end
   endtask

   task automatic drain();
      @(negedge clk);
      poll_en = 1'b0;
      tx_ready = 1'b1;
      for (int t = 0; t < 30; t++) begin
         @(negedge clk);
         if (!tx_valid && !busy) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic run_poll(input int cnt, input int g, input int nframes);
      int p = 0, er, sk;
      pcount = CW'(cnt);
      gap = GW'(g);
      @(negedge clk);
      poll_en = 1'b1;
      for (int i = 0; i < nframes; i++) begin
         grab(0, 1'b0, 0, 8'd0);
         next_entry(p, cnt, er, sk);
         chk(got[2] == er[7:0], "R8 poll order", int'(got[2]), er);
         check_frame(22, er, "poll");
         if (i > 0) begin
            if (sk > 0) chk(idle_lo == g + 1 + sk, "R9 zero entry skip time", idle_lo, g + 1 + sk);
            else        chk(idle_lo == g + 1, "R8 poll gap", idle_lo, g + 1);
         end
      end
      drain();
   endtask

   initial begin
      int alist [4] = '{22, 0, 240, 255};
      repeat (4) @(negedge clk);
      chk(!tx_valid && !busy && !done, "R5 reset state", int'(tx_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: register index 0 produces nothing
      addr = 8'd22;
      regi = 8'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      begin
         bit seen = 1'b0;
         repeat (8) begin
            @(negedge clk);
            if (tx_valid || busy) seen = 1'b1;
         end
         chk(!seen, "R7 zero index ignored", int'(seen), 0);
      end

      // sweep: addresses x all nonzero indices x stall patterns
      foreach (alist[ai]) begin
         for (int r = 1; r < 256; r++) begin
            addr = alist[ai][7:0];
            regi = r[7:0];
            start = 1'b1;
            grab(r % 3, (r % 7) == 0, 0, 8'd0);
            check_frame(alist[ai], r, "sweep");
            if ((r % 7) == 0) begin
               @(negedge clk);
               chk(!tx_valid && !busy, "R6 start during frame ignored", int'(tx_valid), 0);
            end
         end
      end

      // polling
      addr = 8'd22;
      lst = '{5, 0, 9, 13};
      plist = {8'd13, 8'd9, 8'd0, 8'd5};
      run_poll(4, 0, 7);
      run_poll(4, 3, 7);
      run_poll(2, 1, 4);
      run_poll(0, 2, 3);

      // R10: manual start in the poll launch cycle
      begin
         int g = 2;
         pcount = CW'(4);
         gap = GW'(g);
         @(negedge clk);
         poll_en = 1'b1;
         grab(0, 1'b0, 0, 8'd0);
         chk(got[2] == 8'd5, "R8 first poll entry", int'(got[2]), 5);
         grab(0, 1'b0, 0, 8'd0);
         chk(got[2] == 8'd9, "R9 skip before collision", int'(got[2]), 9);
         grab(0, 1'b0, g + 1, 8'd20);
         chk(got[2] == 8'd20, "R10 manual start wins", int'(got[2]), 20);
         chk(idle_lo == g + 1, "R10 manual launch cycle", idle_lo, g + 1);
         check_frame(22, 20, "collision");
         grab(0, 1'b0, 0, 8'd0);
         chk(got[2] == 8'd13, "R10 poll position kept", int'(got[2]), 13);
         chk(idle_lo == g + 1, "R10 gap after manual frame", idle_lo, g + 1);
         drain();
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule